// File: doc/BRIEF.md
# Still-Capture Exposure and Readout Sequencer

This block runs a still-image capture on an image sensor timing generator. A start request launches an exposure of a programmed number of vertical fields. Readout fields follow on their own, with no further write. While the capture runs, the block holds off the electronic shutter pulses. During exposure it can also hold off the vertical transfer gates. It drives three capture outputs: a substrate bias output, a flash strobe and a mechanical shutter control. Each one switches at a programmed line or line/pixel position inside the exposure fields.

Settings come in through a simple write port into a staged copy. The staged copy is applied to the working copy only on the combined vertical/horizontal sync falling edge (`vd_fall`). Software can therefore prepare the next field at any time. The external timing generator supplies the line and pixel counters and the sync pulse.

Register addresses on `wr_addr`:
- 0 holds the control word.
- 1 holds the exposure field count.
- 2 holds the readout field count.
- 3 holds the substrate mode in bit 0.
- 4 holds the substrate turn-on line in its low 10 bits.
- 5 holds the strobe on position and 6 the strobe off position.
- 7 holds the shutter close position.
- 8 is the shutter reopen request; its data is ignored.

Positions are `{line[9:0], pixel[11:0]}`. In the control word, bit 0 enables the strobe, bit 1 the mechanical shutter, bit 2 the substrate output, bit 3 the transfer-gate hold-off, and bit 4 is start.

Top module: `exposure_readout_seq`

## Requirements
- R1: A write lands in the staged copy only. Outputs and state change from it no earlier than the clock edge that samples the next `vd_fall`.
- R2: When start (control bit 4) is staged and the block is idle, the sync edge begins exposure. The staged start bit then clears, so one write gives exactly one capture.
- R3: Exposure lasts max(exposure count,1) fields. During it `subck_en` is 0, and `vsg_en` is 0 if control bit 3 is set (1 otherwise). Phase changes happen only on sync edges.
- R4: After the last exposure field, readout runs by itself for max(readout count,1) fields, each begun by a sync edge. During readout `subck_en` is 0 and `vsg_en` is 1.
- R5: `busy` is 1 from the sync edge that starts exposure until the sync edge that ends the last readout field. A start applied while busy is dropped.
- R6: With substrate mode 0 and control bit 2 set, `vsub` goes to 1 when the line counter equals the turn-on line during an exposure field.
- R7: With substrate mode 1 and control bit 2 set, `vsub` goes to 1 on line 0 of an exposure field.
- R8: With control bit 0 set, `strobe` goes to 1 at the on position and to 0 at the off position during exposure. Off wins when both match.
- R9: With control bit 1 set, `mshut_open` goes to 0 at the close position during exposure. It returns to 1 only on the sync edge after a write to address 8.
- R10: At the end of the capture `vsub` and `strobe` return to 0 and `subck_en` and `vsg_en` to 1. An output whose control bit is 0 never leaves its idle level.
- R11: After reset the outputs are `busy`=0, `subck_en`=1, `vsg_en`=1, `vsub`=0, `strobe`=0, `mshut_open`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vd_fall | input | 1 | One-cycle pulse at the vertical/horizontal sync falling edge |
| line_cnt | input | 10 | Current line within the field |
| pix_cnt | input | 12 | Current pixel within the line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 22 | Register write data |
| busy | output | 1 | Capture in progress |
| subck_en | output | 1 | Electronic shutter pulses allowed |
| vsg_en | output | 1 | Transfer gate pulses allowed |
| vsub | output | 1 | Substrate bias output |
| strobe | output | 1 | Flash strobe output |
| mshut_open | output | 1 | Mechanical shutter control, 1 means open |

## Verification
The bench sweeps every pixel of every line of a small field, one cycle per position, so each on, off and close position is hit exactly once per field. Sweeping exposure and readout counts 0 to 3 in all sixteen pairs separates field counting from the zero-means-one rule. The length of each capture is checked against the sum of the two counts.

Further runs cover these cases:
- The two substrate modes, which tell line-match turn-on apart from first-line turn-on.
- An equal strobe on/off position, which exposes the off-priority rule.
- Masked control words, which show that disabled outputs stay idle.
- Writes with no sync, which show staging.
- A start written while busy, which must be dropped.

// File: rtl/exr_pkg.sv
package exr_pkg;

    localparam int LINE_W = 10;
    localparam int PIX_W  = 12;
    localparam int POS_W  = LINE_W + PIX_W;
    localparam int CNT_W  = 4;
    localparam int ADDR_W = 4;
    localparam int DATA_W = POS_W;
    localparam int TRG_W  = 5;

    localparam int TRG_STROBE = 0;
    localparam int TRG_SHUT   = 1;
    localparam int TRG_SUB    = 2;
    localparam int TRG_GATE   = 3;
    localparam int TRG_GO     = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL     = 4'd0,
        A_EXP_N    = 4'd1,
        A_RD_N     = 4'd2,
        A_SUB_MODE = 4'd3,
        A_SUB_LINE = 4'd4,
        A_STRB_ON  = 4'd5,
        A_STRB_OFF = 4'd6,
        A_SHUT_OFF = 4'd7,
        A_SHUT_ON  = 4'd8
    } addr_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_EXPOSE = 2'd1,
        PH_READ   = 2'd2
    } phase_e;

    typedef struct packed {
        logic [TRG_W-1:0]  ctrl;
        logic [CNT_W-1:0]  exp_n;
        logic [CNT_W-1:0]  rd_n;
        logic              sub_mode;
        logic [LINE_W-1:0] sub_line;
        logic [POS_W-1:0]  strb_on;
        logic [POS_W-1:0]  strb_off;
        logic [POS_W-1:0]  shut_off;
    } cfg_t;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] n);
        return (n == '0) ? CNT_W'(1) : n;
    endfunction

endpackage

// File: rtl/exr_cfg_stage.sv
module exr_cfg_stage
    import exr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              staged,
    output cfg_t              active,
    output logic              reopen_go
);

    logic reopen_pend;

    assign reopen_go = sync & reopen_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged      <= '0;
            active      <= '0;
            reopen_pend <= 1'b0;
        end else begin
            if (sync) begin
                active              <= staged;
                staged.ctrl[TRG_GO] <= 1'b0;
                reopen_pend         <= 1'b0;
            end
            if (wr_en) begin
                case (addr_e'(wr_addr))
                    A_CTRL:     staged.ctrl     <= wr_data[TRG_W-1:0];
                    A_EXP_N:    staged.exp_n    <= wr_data[CNT_W-1:0];
                    A_RD_N:     staged.rd_n     <= wr_data[CNT_W-1:0];
                    A_SUB_MODE: staged.sub_mode <= wr_data[0];
                    A_SUB_LINE: staged.sub_line <= wr_data[LINE_W-1:0];
                    A_STRB_ON:  staged.strb_on  <= wr_data[POS_W-1:0];
                    A_STRB_OFF: staged.strb_off <= wr_data[POS_W-1:0];
                    A_SHUT_OFF: staged.shut_off <= wr_data[POS_W-1:0];
                    A_SHUT_ON:  reopen_pend     <= 1'b1;
                    default:    ;
                endcase
            end
        end
    end

    // Working settings move only on a sync edge
    assert_active_held_R1: assert property (@(posedge clk) disable iff (rst)
        !sync |=> $stable(active));

endmodule

// File: rtl/exr_field_seq.sv
module exr_field_seq
    import exr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync,
    input  logic             go_req,
    input  logic [CNT_W-1:0] exp_n,
    input  logic [CNT_W-1:0] rd_n,
    output phase_e           phase,
    output logic             seq_end
);

    logic [CNT_W-1:0] left;
    logic             last_field;

    assign last_field = (left <= CNT_W'(1));
    assign seq_end    = sync && (phase == PH_READ) && last_field;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            left  <= '0;
        end else if (sync) begin
            case (phase)
                PH_IDLE: if (go_req) begin
                    phase <= PH_EXPOSE;
                    left  <= at_least_one(exp_n);
                end
                PH_EXPOSE: if (!last_field) begin
                    left <= left - CNT_W'(1);
                end else begin
                    phase <= PH_READ;
                    left  <= at_least_one(rd_n);
                end
                PH_READ: if (!last_field) begin
                    left <= left - CNT_W'(1);
                end else begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_phase_at_sync_R3: assert property (@(posedge clk) disable iff (rst)
        !sync |=> $stable(phase));

    assert_read_follows_R4: assert property (@(posedge clk) disable iff (rst)
        (sync && phase == PH_EXPOSE && last_field) |=> phase == PH_READ);

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !(sync && go_req)) |=> phase == PH_IDLE);

endmodule

// File: rtl/exr_event_out.sv
module exr_event_out
    import exr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  cfg_t              cfg,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [PIX_W-1:0]  pix_cnt,
    input  logic              seq_end,
    input  logic              reopen_go,
    output logic              vsub,
    output logic              strobe,
    output logic              mshut_open
);

    logic [POS_W-1:0] pos;
    logic             in_exp;
    logic             sub_hit;

    assign pos     = {line_cnt, pix_cnt};
    assign in_exp  = (phase == PH_EXPOSE);
    assign sub_hit = cfg.sub_mode ? (line_cnt == '0) : (line_cnt == cfg.sub_line);

    always_ff @(posedge clk) begin
        if (rst) begin
            vsub       <= 1'b0;
            strobe     <= 1'b0;
            mshut_open <= 1'b1;
        end else begin
            if (seq_end)
                vsub <= 1'b0;
            else if (in_exp && cfg.ctrl[TRG_SUB] && sub_hit)
                vsub <= 1'b1;

            if (seq_end)
                strobe <= 1'b0;
            else if (in_exp && cfg.ctrl[TRG_STROBE]) begin
                if (pos == cfg.strb_off)
                    strobe <= 1'b0;
                else if (pos == cfg.strb_on)
                    strobe <= 1'b1;
            end

            if (reopen_go)
                mshut_open <= 1'b1;
            else if (in_exp && cfg.ctrl[TRG_SHUT] && pos == cfg.shut_off)
                mshut_open <= 1'b0;
        end
    end

    assert_vsub_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(vsub) |-> $past(in_exp && cfg.ctrl[TRG_SUB]));

    assert_strobe_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe) |-> $past(in_exp && cfg.ctrl[TRG_STROBE]));

    assert_shut_close_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(mshut_open) |-> $past(in_exp && cfg.ctrl[TRG_SHUT]));

    assert_idle_outputs_R10: assert property (@(posedge clk) disable iff (rst)
        seq_end |=> (!vsub && !strobe));

endmodule

// File: rtl/exposure_readout_seq.sv
module exposure_readout_seq
    import exr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vd_fall,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [PIX_W-1:0]  pix_cnt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              subck_en,
    output logic              vsg_en,
    output logic              vsub,
    output logic              strobe,
    output logic              mshut_open
);

    cfg_t   staged;
    cfg_t   active;
    logic   reopen_go;
    phase_e phase;
    logic   seq_end;

    exr_cfg_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .sync      (vd_fall),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .staged    (staged),
        .active    (active),
        .reopen_go (reopen_go)
    );

    exr_field_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .sync    (vd_fall),
        .go_req  (staged.ctrl[TRG_GO]),
        .exp_n   (staged.exp_n),
        .rd_n    (active.rd_n),
        .phase   (phase),
        .seq_end (seq_end)
    );

    exr_event_out u_evt (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .cfg        (active),
        .line_cnt   (line_cnt),
        .pix_cnt    (pix_cnt),
        .seq_end    (seq_end),
        .reopen_go  (reopen_go),
        .vsub       (vsub),
        .strobe     (strobe),
        .mshut_open (mshut_open)
    );

    assign busy     = (phase != PH_IDLE);
    assign subck_en = (phase == PH_IDLE);
    assign vsg_en   = !((phase == PH_EXPOSE) && active.ctrl[TRG_GATE]);

    assert_busy_rise_sync_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(vd_fall));

    assert_gates_readout_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ) |-> (vsg_en && !subck_en));

endmodule

// File: tb/exposure_readout_seq_tb.sv
`timescale 1ns/1ps
module exposure_readout_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vd_fall = 1'b0;
    logic [9:0]  line_cnt = '0;
    logic [11:0] pix_cnt = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [21:0] wr_data = '0;
    logic busy, subck_en, vsg_en, vsub, strobe, mshut_open;

    int n_chk = 0;
    int n_err = 0;
    bit live = 1'b0;

    always #2 clk = ~clk;

    exposure_readout_seq dut_i (
        .clk(clk), .rst(rst), .vd_fall(vd_fall), .line_cnt(line_cnt), .pix_cnt(pix_cnt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
        .subck_en(subck_en), .vsg_en(vsg_en), .vsub(vsub), .strobe(strobe),
        .mshut_open(mshut_open)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Requirement model, advanced at each rising edge
    logic [21:0] sh [0:15];
    logic [21:0] ac [0:15];
    bit  m_pend;
    int  m_ph, m_left;
    bit  m_vsub, m_strobe, m_mshut;

    function automatic int mx1(input logic [3:0] n);
        return (n == 0) ? 1 : int'(n);
    endfunction

    always @(posedge clk) begin
        logic [21:0] pos;
        bit sq_end, in_exp, hit;
        if (rst) begin
            for (int i = 0; i < 16; i++) begin sh[i] = '0; ac[i] = '0; end
            m_pend = 0; m_ph = 0; m_left = 0;
            m_vsub = 0; m_strobe = 0; m_mshut = 1;
        end else begin
            pos    = {line_cnt, pix_cnt};
            sq_end = vd_fall && m_ph == 2 && m_left <= 1;
            in_exp = (m_ph == 1);
            hit    = ac[3][0] ? (line_cnt == 0) : (line_cnt == ac[4][9:0]);
            if (sq_end) m_vsub = 0;
            else if (in_exp && ac[0][2] && hit) m_vsub = 1;
            if (sq_end) m_strobe = 0;
            else if (in_exp && ac[0][0]) begin
                if (pos == ac[6]) m_strobe = 0;
                else if (pos == ac[5]) m_strobe = 1;
            end
            if (vd_fall && m_pend) m_mshut = 1;
            else if (in_exp && ac[0][1] && pos == ac[7]) m_mshut = 0;
            if (vd_fall) begin
                case (m_ph)
                    0: if (sh[0][4]) begin m_ph = 1; m_left = mx1(sh[1][3:0]); end
                    1: if (m_left > 1) m_left--; else begin m_ph = 2; m_left = mx1(ac[2][3:0]); end
                    default: if (m_left > 1) m_left--; else m_ph = 0;
                endcase
                for (int i = 0; i < 16; i++) ac[i] = sh[i];
                sh[0][4] = 1'b0;
                m_pend = 0;
            end
            if (wr_en) begin
                sh[wr_addr] = wr_data;
                if (wr_addr == 4'd8) m_pend = 1;
            end
        end
    end

    // Cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (live && !rst) begin
            chk("R5 busy", busy, int'(m_ph != 0));
            chk("R3 R4 subck_en", subck_en, int'(m_ph == 0));
            chk("R3 R4 vsg_en", vsg_en, int'(!(m_ph == 1 && ac[0][3])));
            chk("R6 R7 vsub", vsub, int'(m_vsub));
            chk("R8 strobe", strobe, int'(m_strobe));
            chk("R9 mshut_open", mshut_open, int'(m_mshut));
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = 4'(a); wr_data = 22'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic field();
        vd_fall = 1; line_cnt = 0; pix_cnt = 0;
        @(negedge clk);
        vd_fall = 0;
        for (int l = 0; l < 8; l++)
            for (int p = 0; p < 4; p++) begin
                line_cnt = 10'(l); pix_cnt = 12'(p);
                @(negedge clk);
            end
    endtask

    function automatic int ps(input int l, input int p);
        return (l << 12) | p;
    endfunction

    task automatic run_seq(output int n);
        n = 0;
        field();
        for (int k = 0; k < 20 && busy; k++) begin
            n++;
            field();
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        report();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 subck_en", subck_en, 1);
        chk("R11 vsg_en", vsg_en, 1);
        chk("R11 vsub", vsub, 0);
        chk("R11 strobe", strobe, 0);
        chk("R11 mshut_open", mshut_open, 1);
        live = 1;

        // R1: staged writes without a sync edge change nothing
        wr(1, 1); wr(2, 3); wr(3, 0); wr(4, 2);
        wr(5, ps(1, 1)); wr(6, ps(4, 2)); wr(7, ps(5, 0));
        wr(0, 31);
        repeat (5) @(negedge clk);
        chk("R1 busy before sync", busy, 0);
        chk("R1 subck before sync", subck_en, 1);

        // R2 R3 R4 R5: full capture, count busy fields
        run_seq(n);
        chk("R4 R5 field count 1+3", n, 4);
        chk("R9 shutter held closed", mshut_open, 0);
        field();
        chk("R2 start self-clears", busy, 0);
        wr(8, 0);
        chk("R9 reopen waits for sync", mshut_open, 0);
        field();
        chk("R9 reopened", mshut_open, 1);

        // R7: substrate mode 1, transfer gates not held, shutter masked (R10)
        wr(1, 2); wr(2, 0); wr(3, 1); wr(4, 6);
        wr(0, 5'b10101);
        field();
        chk("R7 vsub at first line", vsub, 1);
        chk("R10 vsg stays enabled", vsg_en, 1);
        n = 1;
        for (int k = 0; k < 20 && busy; k++) begin n++; field(); end
        n--;
        chk("R3 R4 field count 2+1", n, 3);
        chk("R10 vsub cleared", vsub, 0);
        chk("R10 shutter untouched", mshut_open, 1);

        // R8: equal on/off position, off wins
        wr(1, 1); wr(2, 1); wr(5, ps(3, 3)); wr(6, ps(3, 3));
        wr(0, 5'b10001);
        run_seq(n);
        chk("R8 equal positions", strobe, 0);

        // R10: only start bit set, outputs remain idle (model checks each cycle)
        wr(5, ps(2, 0)); wr(6, ps(6, 0));
        wr(0, 5'b10000);
        run_seq(n);
        chk("R10 strobe masked", strobe, 0);
        chk("R10 vsub masked", vsub, 0);

        // R5: start written while busy is dropped
        wr(1, 2); wr(2, 1); wr(0, 31);
        field();
        wr(0, 31);
        n = 1;
        for (int k = 0; k < 20 && busy; k++) begin n++; field(); end
        n--;
        chk("R5 capture length unaffected", n, 3);
        field();
        chk("R5 start while busy ignored", busy, 0);
        wr(8, 0); field();

        // Sweep exposure and readout counts, including zero
        wr(3, 0); wr(4, 3);
        wr(5, ps(1, 2)); wr(6, ps(6, 1)); wr(7, ps(4, 3));
        for (int e = 0; e < 4; e++)
            for (int r = 0; r < 4; r++) begin
                wr(1, e); wr(2, r); wr(0, 31);
                run_seq(n);
                chk("R3 R4 swept field count", n, mx1(4'(e)) + mx1(4'(r)));
                wr(8, 0); field();
            end

        live = 0;
        report();
    end

endmodule